// File: doc/BRIEF.md
# Level-One Cache Control Register with Invalidate Walker

This block holds the 32-bit control and status word of a level-one cache and contains the sequencer that invalidates the whole cache. Software reaches the word over a single-register write port, and the read data is always present. The word carries four live fields: a cache enable, a geometry select, a self-clearing invalidate command and a sticky abort flag. Every other bit reads as zero and ignores writes.

Writing the invalidate bit as 1 while the block is idle moves the sequencer from state IDLE to state WALK (transition START). In WALK the sequencer clears the valid bits of one set per clock, across all ways at once, through a set-wide clear port toward the tag array. It starts at set 0 and counts upward. Geometry 0 (eight ways) has 128 sets and geometry 1 (four ways, the lower-power choice) has 256 sets. The geometry is captured at START. WALK returns to IDLE by one of two transitions. DONE follows the clear of the last set. ABORT is taken when the external abort input is high, and it also sets the abort flag. While WALK is active, `busy` is high and the lookup path is told to miss. Software can write the abort flag to 0 but cannot set it.

Top module: `cachectl_csr`

## Requirements
- R1: After reset, `csr_rdata` is 0 and `busy`, `lookup_en` and `tag_clr_en` are low.
- R2: Fields use LSB-0 positions. Bit 0 is enable, bit 1 is invalidate, bit 2 is the abort flag and bit 4 is geometry. Each write loads bits 0 and 4 from `csr_wdata`. All other bits read 0 whatever was written.
- R3: `lookup_en` is high exactly when enable is 1 and `busy` is low.
- R4: A write with bit 1 = 1 while idle raises `busy` in the next cycle. The walk then asserts `tag_clr_en` once per cycle with `tag_clr_set` equal to 0, 1, 2 and so on. Bit 1 reads 1 throughout the walk.
- R5: The walk clears 128 sets when geometry was 0 at START and 256 sets when it was 1. A geometry change during the walk does not alter the count.
- R6: After the last set has been cleared, `busy` falls and bit 1 reads 0 without any software action.
- R7: A write with bit 1 = 0 during a walk does not stop or shorten it.
- R8: If `abort_req` is high during a walk, no set is cleared in that cycle. `busy` is low in the next cycle, and bit 2 then reads 1.
- R9: The abort flag stays 1 until a write with bit 2 = 0. A write with bit 2 = 1 never sets it, and `abort_req` while idle leaves it unchanged.
- R10: The invalidation walk runs to full length with enable at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wen | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data |
| abort_req | input | 1 | External request to stop a running walk |
| busy | output | 1 | Invalidate walk in progress |
| lookup_en | output | 1 | Lookup path may hit |
| tag_clr_en | output | 1 | Clear the valid bits of every way in one set |
| tag_clr_set | output | 8 | Index of the set being cleared |

## Verification
The hardest states to reach are the ones where a walk is interrupted at an exact step. These are an abort at step 0, an abort on the last set of a 256-set walk, and a write during the walk that also changes geometry. The bench steps through each walk one clock at a time. At a chosen step index it drives the abort or the write on the falling edge, then counts the clears that follow. The expected length comes from the step index and the geometry captured at START.

// File: rtl/cc_pkg.sv
package cc_pkg;

    localparam int CSR_W       = 32;
    localparam int BIT_ENABLE  = 0;
    localparam int BIT_INVAL   = 1;
    localparam int BIT_ABORT   = 2;
    localparam int BIT_GEOM    = 4;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_WALK = 1'b1
    } seq_state_t;

endpackage

// File: rtl/cc_ctl_regs.sv
module cc_ctl_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic wen,
    input  logic wr_enable,
    input  logic wr_geom,
    input  logic wr_abort,
    input  logic abort_set,
    output logic enable_q,
    output logic geom_q,
    output logic abort_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= 1'b0;
            geom_q   <= 1'b0;
        end else if (wen) begin
            enable_q <= wr_enable;
            geom_q   <= wr_geom;
        end
    end

    // Hardware set wins over a software clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            abort_q <= 1'b0;
        end else if (abort_set) begin
            abort_q <= 1'b1;
        end else if (wen && !wr_abort) begin
            abort_q <= 1'b0;
        end
    end

endmodule

// File: rtl/cc_inv_seq.sv
module cc_inv_seq
    import cc_pkg::*;
#(
    parameter int SETS_SMALL = 128,
    parameter int SETS_LARGE = 256,
    parameter int SET_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             geom,
    input  logic             abort_req,
    output logic             busy,
    output logic             clr_en,
    output logic [SET_W-1:0] clr_set,
    output logic             aborted
);

    localparam logic [SET_W-1:0] LAST_SMALL = SET_W'(SETS_SMALL - 1);
    localparam logic [SET_W-1:0] LAST_LARGE = SET_W'(SETS_LARGE - 1);

    seq_state_t       state_q, state_nx;
    logic [SET_W-1:0] cnt_q, cnt_nx;
    logic [SET_W-1:0] last_q, last_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            last_q  <= '0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
            last_q  <= last_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        last_nx  = last_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (start) begin
                    state_nx = SEQ_WALK;
                    cnt_nx   = '0;
                    last_nx  = geom ? LAST_LARGE : LAST_SMALL;
                end
            end
            SEQ_WALK: begin
                if (abort_req) begin
                    state_nx = SEQ_IDLE;
                end else if (cnt_q == last_q) begin
                    state_nx = SEQ_IDLE;
                end else begin
                    cnt_nx = cnt_q + SET_W'(1);
                end
            end
            default: state_nx = SEQ_IDLE;
        endcase
    end

    always_comb begin
        busy    = 1'b0;
        clr_en  = 1'b0;
        aborted = 1'b0;
        unique case (state_q)
            SEQ_IDLE: ;
            SEQ_WALK: begin
                busy    = 1'b1;
                clr_en  = !abort_req;
                aborted = abort_req;
            end
            default: ;
        endcase
    end

    assign clr_set = cnt_q;

endmodule

// File: rtl/cachectl_csr.sv
module cachectl_csr
    import cc_pkg::*;
#(
    parameter int SETS_SMALL = 128,
    parameter int SETS_LARGE = 256
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           csr_wen,
    input  logic [CSR_W-1:0]               csr_wdata,
    output logic [CSR_W-1:0]               csr_rdata,
    input  logic                           abort_req,
    output logic                           busy,
    output logic                           lookup_en,
    output logic                           tag_clr_en,
    output logic [$clog2(SETS_LARGE)-1:0]  tag_clr_set
);

    localparam int SET_W = $clog2(SETS_LARGE);

    logic enable_q, geom_q, abort_q;
    logic start, aborted;
    logic unused_wbits;

    assign unused_wbits = ^{csr_wdata[CSR_W-1:BIT_GEOM+1], csr_wdata[BIT_GEOM-1:BIT_ABORT+1]};

    assign start = csr_wen && csr_wdata[BIT_INVAL] && !busy;

    cc_ctl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wen       (csr_wen),
        .wr_enable (csr_wdata[BIT_ENABLE]),
        .wr_geom   (csr_wdata[BIT_GEOM]),
        .wr_abort  (csr_wdata[BIT_ABORT]),
        .abort_set (aborted),
        .enable_q  (enable_q),
        .geom_q    (geom_q),
        .abort_q   (abort_q)
    );

    cc_inv_seq #(
        .SETS_SMALL (SETS_SMALL),
        .SETS_LARGE (SETS_LARGE),
        .SET_W      (SET_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .geom      (csr_wdata[BIT_GEOM]),
        .abort_req (abort_req),
        .busy      (busy),
        .clr_en    (tag_clr_en),
        .clr_set   (tag_clr_set),
        .aborted   (aborted)
    );

    always_comb begin
        csr_rdata             = '0;
        csr_rdata[BIT_ENABLE] = enable_q;
        csr_rdata[BIT_INVAL]  = busy;
        csr_rdata[BIT_ABORT]  = abort_q;
        csr_rdata[BIT_GEOM]   = geom_q;
    end

    assign lookup_en = enable_q && !busy;

endmodule

// File: rtl/cachectl_csr_chk.sv
module cachectl_csr_chk #(
    parameter int SETS_SMALL = 128,
    parameter int SETS_LARGE = 256,
    parameter int SET_W      = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             csr_wen,
    input logic [31:0]      csr_wdata,
    input logic [31:0]      csr_rdata,
    input logic             abort_req,
    input logic             busy,
    input logic             lookup_en,
    input logic             tag_clr_en,
    input logic [SET_W-1:0] tag_clr_set
);

    assert_lookup_off_walk_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !lookup_en);

    assert_clear_inside_walk_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tag_clr_en |-> busy);

    assert_walk_starts_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (tag_clr_set == '0) && $past(csr_wen && csr_wdata[1]));

    assert_walk_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tag_clr_en |=> (!tag_clr_en || tag_clr_set == $past(tag_clr_set) + SET_W'(1)));

    assert_walk_ends_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(abort_req)) |->
            ($past(tag_clr_set) == SET_W'(SETS_SMALL - 1) ||
             $past(tag_clr_set) == SET_W'(SETS_LARGE - 1)));

    assert_abort_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort_req) |=> (!busy && csr_rdata[2]));

    assert_abort_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[2] && !(csr_wen && !csr_wdata[2])) |=> csr_rdata[2]);

endmodule

bind cachectl_csr cachectl_csr_chk #(
    .SETS_SMALL (SETS_SMALL),
    .SETS_LARGE (SETS_LARGE),
    .SET_W      (SET_W)
) u_chk (.*);

// File: tb/tb_cachectl_csr.sv
`timescale 1ns/1ps
module tb_cachectl_csr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wen = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        abort_req = 1'b0;
    logic        busy, lookup_en, tag_clr_en;
    logic [7:0]  tag_clr_set;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cachectl_csr dut (.*);

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        csr_wen = 1'b1;
        csr_wdata = d;
        @(negedge clk);
        csr_wen = 1'b0;
        csr_wdata = '0;
    endtask

    // Called at the falling edge right after the start write.
    task automatic run_walk(input int exp_n, input int wr_at, input logic [31:0] wr_d,
                            input int ab_at, input string req);
        int seen = 0;
        bit order_ok = 1'b1;
        bit look_ok = 1'b1;
        check(busy === 1'b1 && csr_rdata[1] === 1'b1, "R4", busy, 1);
        for (int k = 0; k < 400 && busy; k++) begin
            csr_wen   = (k == wr_at);
            csr_wdata = (k == wr_at) ? wr_d : '0;
            abort_req = (k == ab_at);
            #1;
            if (tag_clr_en) begin
                if (tag_clr_set != 8'(seen)) order_ok = 1'b0;
                seen++;
            end
            if (lookup_en !== 1'b0) look_ok = 1'b0;
            @(negedge clk);
        end
        csr_wen = 1'b0;
        csr_wdata = '0;
        abort_req = 1'b0;
        check(order_ok, "R4", 0, 1);
        check(look_ok, "R3", 0, 1);
        check(seen == exp_n, req, seen, exp_n);
        check(busy === 1'b0 && csr_rdata[1] === 1'b0, "R6", busy, 0);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(csr_rdata === 32'h0, "R1", csr_rdata, 0);
        check(busy === 1'b0 && lookup_en === 1'b0 && tag_clr_en === 1'b0, "R1", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(csr_rdata === 32'h0, "R1", csr_rdata, 0);

        // R2 / R3 / R9: sweep the low field bits with all reserved bits set
        for (int v = 0; v < 32; v++) begin
            if (v[1]) continue;
            wr(32'hFFFF_FFE8 | 32'(v));
            check(csr_rdata === (32'(v) & 32'h11), "R2", csr_rdata, 32'(v) & 32'h11);
            check(lookup_en === v[0], "R3", lookup_en, v[0]);
            check(csr_rdata[2] === 1'b0, "R9", csr_rdata[2], 0);
        end

        // R4/R5: geometry 0, enable on, full walk of 128
        wr(32'h0000_0011 & 32'h0000_0001);
        wr(32'h0000_0003);
        run_walk(128, -1, '0, -1, "R5");
        check(csr_rdata === 32'h1 && lookup_en === 1'b1, "R6", csr_rdata, 1);

        // R10/R7/R5: geometry 1, enable off; mid-walk write of 0 to
        // invalidate that also flips geometry back to 0
        wr(32'h0000_0012);
        run_walk(256, 10, 32'h0000_0000, -1, "R7");
        check(csr_rdata === 32'h0, "R10", csr_rdata, 0);

        // R8: abort at step 40, geometry 0
        wr(32'h0000_0003);
        run_walk(40, -1, '0, 40, "R8");
        check(csr_rdata === 32'h5, "R8", csr_rdata, 5);
        check(lookup_en === 1'b1, "R3", lookup_en, 1);

        // R9: abort while idle has no effect; write 1 keeps; write 0 clears
        abort_req = 1'b1;
        @(negedge clk);
        abort_req = 1'b0;
        @(negedge clk);
        check(csr_rdata === 32'h5, "R9", csr_rdata, 5);
        wr(32'h0000_0004);
        check(csr_rdata === 32'h4, "R9", csr_rdata, 4);
        wr(32'h0000_0000);
        check(csr_rdata === 32'h0, "R9", csr_rdata, 0);
        abort_req = 1'b1;
        @(negedge clk);
        abort_req = 1'b0;
        @(negedge clk);
        check(csr_rdata === 32'h0 && busy === 1'b0, "R9", csr_rdata, 0);

        // R8: abort on the very first step
        wr(32'h0000_0002);
        run_walk(0, -1, '0, 0, "R8");
        check(csr_rdata === 32'h4, "R8", csr_rdata, 4);

        // R8: abort on the last set of a 256-set walk
        wr(32'h0000_0000);
        wr(32'h0000_0012);
        run_walk(255, -1, '0, 255, "R8");
        check(csr_rdata === 32'h14, "R8", csr_rdata, 32'h14);

        // R5: geometry 1 full walk again after an abort, enable on
        wr(32'h0000_0013);
        run_walk(256, -1, '0, -1, "R5");
        check(csr_rdata === 32'h11, "R6", csr_rdata, 32'h11);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule